// File: doc/BRIEF.md
# Interleaved Active-Clamp PWM Sequencer

This block turns one oscillator tick stream into two interleaved PWM phases for a dual-phase converter with active-clamp switches. Oscillator ticks are handed to the two phases in turn, so each phase repeats once every two oscillator periods. The start of phase B's cycle falls exactly one oscillator period after the start of phase A's cycle. Each phase drives a main-switch gate command and a clamp-switch gate command. The clamp command is high whenever its main command is high. It is also high for an overlap window of equal length just before the main turn-on and just after the main turn-off.

Each phase has its own on-time input. A single overlap count, given in clock cycles, applies to both phases. Both values are captured only when a phase cycle starts. The block measures the oscillator period itself in clock cycles. It limits each on-time so that the overlap windows and the main pulse together fit inside the two-period phase cycle. On-times that are too short are dropped completely. A thermal fault turns all gates off and keeps them off until the enable is lowered and raised again.

Top module: `interleaved_clamp_pwm`

## Requirements
- R1: While `rst` is high, and on every edge where `enable` is low, all four gate outputs are low after that edge, and the phase selection returns to phase A.
- R2: Accepted ticks alternate between the phases, and the first accepted tick after the block is released always starts phase A. With equal overlap settings, the rising edge of `main_b` follows the rising edge of `main_a` by exactly one oscillator period.
- R3: If a tick that starts a phase is sampled at edge n, the effective on-time d and overlap v are latched. The phase's main output is then high after edges n+1+v through n+v+d, which is exactly d cycles.
- R4: Each phase takes its on-time only from its own duty input (`duty_a` for phase A, `duty_b` for phase B).
- R5: The clamp output of a phase is high after edges n+1 through n+2v+d. It therefore leads the main rising edge by v cycles and trails the main falling edge by v cycles. With v = 0 the clamp edges coincide with the main edges.
- R6: The oscillator period P is the number of clock edges between the starting tick and the tick before it. The effective on-time is min(duty, 2P − 2v). If 2v ≥ 2P, the phase cycle produces no pulse.
- R7: If the effective on-time is below MIN_ON (default 2), neither the main output nor the clamp output of that phase goes high during that phase cycle.
- R8: Changes to duty or overlap inputs during a phase cycle do not alter that cycle's pulse. They take effect at the next start of that phase.
- R9: The first tick after release has no measured period. The phase-A cycle it starts is empty, and pulses begin with the second tick, which starts phase B.
- R10: On an edge where `fault` is high, all four outputs are low after that edge. They stay low after the fault clears until `enable` is low on at least one edge and is then raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run request; low stops all gates and rearms after a fault |
| fault | input | 1 | Thermal fault flag |
| osc_tick | input | 1 | One-cycle oscillator tick |
| duty_a | input | 8 | Phase A on-time in clock cycles |
| duty_b | input | 8 | Phase B on-time in clock cycles |
| ovl | input | 6 | Overlap count in clock cycles |
| main_a | output | 1 | Phase A main-switch gate |
| clamp_a | output | 1 | Phase A clamp-switch gate |
| main_b | output | 1 | Phase B main-switch gate |
| clamp_b | output | 1 | Phase B clamp-switch gate |

## Verification
The hardest state to reach is the corner where the on-time limit is active. In that corner the overlap windows and the main pulse fill the whole two-period phase cycle, so the clamp stays high across one cycle boundary into the next. The stimulus reaches it by asking for an on-time well above 2P − 2v at a fixed tick spacing. It then raises the overlap past one period to empty the cycle completely. Changes to the tick spacing happen only while the block is disabled, so no phase cycle is ever cut short by an early tick. The duty inputs are also changed at odd intervals during pulses to show that the values captured at the start of a cycle hold.

// File: rtl/iapwm_pkg.sv
package iapwm_pkg;

    localparam int DUTY_W = 8;
    localparam int OVL_W  = 6;
    localparam int PER_W  = 10;
    localparam int CNT_W  = PER_W + 1;
    localparam int NPH    = 2;
    localparam logic [PER_W-1:0] PER_MAX = {PER_W{1'b1}};

    typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] total;   // clamp window length: 2*ovl + on
        logic [CNT_W-1:0] ovl;     // lead and trail overlap
        logic [CNT_W-1:0] on;      // main on-time after limiting
    } plan_t;

    typedef struct packed {
        logic main;
        logic clamp;
    } gate_t;

    function automatic logic [CNT_W-1:0] widen_ovl(input logic [OVL_W-1:0] v);
        return CNT_W'(v);
    endfunction

    // Build the pulse plan for one phase cycle from the sampled inputs.
    function automatic plan_t make_plan(input logic [DUTY_W-1:0] duty,
                                        input logic [OVL_W-1:0]  ovl,
                                        input logic [PER_W-1:0]  per,
                                        input logic              per_ok,
                                        input logic [CNT_W-1:0]  min_on);
        plan_t            p;
        logic [CNT_W-1:0] budget;
        logic [CNT_W-1:0] two_ov;
        logic [CNT_W-1:0] room;
        logic [CNT_W-1:0] d;
        p      = '0;
        budget = {per, 1'b0};
        two_ov = widen_ovl(ovl) << 1;
        room   = '0;
        d      = CNT_W'(duty);
        if (per_ok && (two_ov < budget)) begin
            room = budget - two_ov;
            if (d > room) begin
                d = room;
            end
            if (d >= min_on) begin
                p.total = two_ov + d;
                p.ovl   = widen_ovl(ovl);
                p.on    = d;
            end
        end
        return p;
    endfunction

    function automatic gate_t decode(input logic [CNT_W-1:0] cnt, input plan_t p);
        gate_t g;
        g.clamp = (cnt < p.total);
        g.main  = (cnt >= p.ovl) && (cnt < (p.ovl + p.on));
        return g;
    endfunction

endpackage

// File: rtl/iapwm_sched.sv
module iapwm_sched
    import iapwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             fault,
    input  logic             osc_tick,
    output logic [NPH-1:0]   start,
    output logic [PER_W-1:0] period,
    output logic             per_ok,
    output logic             blocked
);

    phase_e           sel;
    logic             seen;
    logic             flt_lat;
    logic [PER_W-1:0] pcnt;
    logic             run_tick;

    assign blocked  = !enable || fault || flt_lat;
    assign run_tick = osc_tick && !blocked;
    assign period   = pcnt;
    assign per_ok   = seen;

    for (genvar i = 0; i < NPH; i++) begin : g_start
        assign start[i] = run_tick && (int'(sel) == i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_lat <= 1'b0;
            sel     <= PH_A;
            seen    <= 1'b0;
            pcnt    <= '0;
        end else begin
            if (!enable) begin
                flt_lat <= 1'b0;
            end else if (fault) begin
                flt_lat <= 1'b1;
            end
            if (blocked) begin
                sel  <= PH_A;
                seen <= 1'b0;
                pcnt <= '0;
            end else if (osc_tick) begin
                sel  <= (sel == PH_A) ? PH_B : PH_A;
                seen <= 1'b1;
                pcnt <= PER_W'(1);
            end else if (pcnt != PER_MAX) begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    AST_FIRST_TICK_PH_A: assert property (@(posedge clk) disable iff (rst) (run_tick && !seen) |-> start[0]); // R2
    AST_FAULT_STICKS: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(fault) && $past(enable) && enable) |-> blocked); // R10

endmodule

// File: rtl/iapwm_phase.sv
module iapwm_phase
    import iapwm_pkg::*;
#(
    parameter int MIN_ON = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              blocked,
    input  logic              start,
    input  logic [DUTY_W-1:0] duty,
    input  logic [OVL_W-1:0]  ovl,
    input  logic [PER_W-1:0]  period,
    input  logic              per_ok,
    output logic              main_q,
    output logic              clamp_q
);

    localparam logic [CNT_W-1:0] MIN_ON_C = CNT_W'(MIN_ON);

    plan_t            plan_q;
    plan_t            plan_nx;
    gate_t            g;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        plan_nx = make_plan(duty, ovl, period, per_ok, MIN_ON_C);
        g       = decode(cnt, plan_q);
    end

    always_ff @(posedge clk) begin
        if (rst || blocked) begin
            plan_q  <= '0;
            cnt     <= '0;
            main_q  <= 1'b0;
            clamp_q <= 1'b0;
        end else begin
            main_q  <= g.main;
            clamp_q <= g.clamp;
            if (start) begin
                plan_q <= plan_nx;
                cnt    <= '0;
            end else if (cnt < plan_q.total) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_MAIN_WITHIN_CLAMP: assert property (@(posedge clk) disable iff (rst) main_q |-> clamp_q); // R5
    AST_CLAMP_LEADS_MAIN: assert property (@(posedge clk) disable iff (rst) ($rose(main_q) && (plan_q.ovl != '0)) |-> $past(clamp_q)); // R5
    AST_NO_RUNT: assert property (@(posedge clk) disable iff (rst) (plan_q.total != '0) |-> (plan_q.on >= MIN_ON_C)); // R7
    AST_FITS_BUDGET: assert property (@(posedge clk) disable iff (rst) (start && per_ok && !blocked) |=> (plan_q.total <= {$past(period), 1'b0})); // R6
    AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (rst) (start && !per_ok && !blocked) |=> (plan_q.total == '0)); // R9

endmodule

// File: rtl/interleaved_clamp_pwm.sv
module interleaved_clamp_pwm
    import iapwm_pkg::*;
#(
    parameter int MIN_ON = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              fault,
    input  logic              osc_tick,
    input  logic [DUTY_W-1:0] duty_a,
    input  logic [DUTY_W-1:0] duty_b,
    input  logic [OVL_W-1:0]  ovl,
    output logic              main_a,
    output logic              clamp_a,
    output logic              main_b,
    output logic              clamp_b
);

    logic [NPH-1:0]    start;
    logic [PER_W-1:0]  period;
    logic              per_ok;
    logic              blocked;
    logic [DUTY_W-1:0] duty_arr [NPH];
    logic [NPH-1:0]    main_v;
    logic [NPH-1:0]    clamp_v;

    assign duty_arr[0] = duty_a;
    assign duty_arr[1] = duty_b;

    iapwm_sched u_sched (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .fault    (fault),
        .osc_tick (osc_tick),
        .start    (start),
        .period   (period),
        .per_ok   (per_ok),
        .blocked  (blocked)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_phase
        iapwm_phase #(.MIN_ON(MIN_ON)) u_phase (
            .clk     (clk),
            .rst     (rst),
            .blocked (blocked),
            .start   (start[i]),
            .duty    (duty_arr[i]),
            .ovl     (ovl),
            .period  (period),
            .per_ok  (per_ok),
            .main_q  (main_v[i]),
            .clamp_q (clamp_v[i])
        );
    end

    assign main_a  = main_v[0];
    assign clamp_a = clamp_v[0];
    assign main_b  = main_v[1];
    assign clamp_b = clamp_v[1];

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst) !enable |=> !(main_a || clamp_a || main_b || clamp_b)); // R1
    AST_OFF_ON_FAULT: assert property (@(posedge clk) disable iff (rst) fault |=> !(main_a || clamp_a || main_b || clamp_b)); // R10

endmodule

// File: tb/tb_interleaved_clamp_pwm.sv
module tb_interleaved_clamp_pwm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       fault = 1'b0;
    logic       osc_tick = 1'b0;
    logic [7:0] duty_a = 8'd0;
    logic [7:0] duty_b = 8'd0;
    logic [5:0] ovl = 6'd0;
    logic       main_a, clamp_a, main_b, clamp_b;

    always #5 clk = ~clk;

    interleaved_clamp_pwm dut (
        .clk(clk), .rst(rst), .enable(enable), .fault(fault), .osc_tick(osc_tick),
        .duty_a(duty_a), .duty_b(duty_b), .ovl(ovl),
        .main_a(main_a), .clamp_a(clamp_a), .main_b(main_b), .clamp_b(clamp_b)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string scen = "R1";
    bit    done = 1'b0;
    bit    started = 1'b0;
    int    cyc = 0;

    // tick generator
    bit tick_en = 1'b0;
    int tper = 20;
    int tc = 0;
    always @(negedge clk) begin
        if (tick_en) begin
            osc_tick <= (tc == 0);
            tc = (tc + 1) % tper;
        end else begin
            osc_tick <= 1'b0;
            tc = 0;
        end
    end

    // behavioural reference model
    int m_sel, m_seen, m_pcnt, m_flat;
    int m_cnt [2];
    int m_tot [2];
    int m_ov  [2];
    int m_on  [2];
    bit exp_m [2];
    bit exp_c [2];

    task automatic mplan(input int duty, input int ov, input int p, input int ok,
                         output int tot, output int oo, output int on);
        int d;
        tot = 0; oo = 0; on = 0;
        if (ok != 0 && 2 * ov < 2 * p) begin
            d = duty;
            if (d > 2 * p - 2 * ov) d = 2 * p - 2 * ov;
            if (d >= 2) begin
                tot = 2 * ov + d; oo = ov; on = d;
            end
        end
    endtask

    always @(posedge clk) begin
        bit blk;
        int ph, p_meas;
        cyc++;
        started = 1'b1;
        if (rst) begin
            m_sel = 0; m_seen = 0; m_pcnt = 0; m_flat = 0;
            for (int k = 0; k < 2; k++) begin
                m_cnt[k] = 0; m_tot[k] = 0; m_ov[k] = 0; m_on[k] = 0;
                exp_m[k] = 1'b0; exp_c[k] = 1'b0;
            end
        end else begin
            blk = !enable || fault || (m_flat != 0);
            if (!enable) m_flat = 0;
            else if (fault) m_flat = 1;
            if (blk) begin
                m_sel = 0; m_seen = 0; m_pcnt = 0;
                for (int k = 0; k < 2; k++) begin
                    m_cnt[k] = 0; m_tot[k] = 0; m_ov[k] = 0; m_on[k] = 0;
                    exp_m[k] = 1'b0; exp_c[k] = 1'b0;
                end
            end else begin
                for (int k = 0; k < 2; k++) begin
                    exp_c[k] = (m_cnt[k] < m_tot[k]);
                    exp_m[k] = (m_cnt[k] >= m_ov[k]) && (m_cnt[k] < m_ov[k] + m_on[k]);
                end
                ph = osc_tick ? m_sel : -1;
                for (int k = 0; k < 2; k++) begin
                    if (k == ph) begin
                        p_meas = m_pcnt;
                        mplan((k == 0) ? int'(duty_a) : int'(duty_b), int'(ovl), p_meas, m_seen,
                              m_tot[k], m_ov[k], m_on[k]);
                        m_cnt[k] = 0;
                    end else if (m_cnt[k] < m_tot[k]) begin
                        m_cnt[k]++;
                    end
                end
                if (osc_tick) begin
                    m_sel = 1 - m_sel; m_seen = 1; m_pcnt = 1;
                end else if (m_pcnt < 1023) begin
                    m_pcnt++;
                end
            end
        end
    end

    // monitors
    int run_ma = 0, run_ca = 0, run_mb = 0;
    int w_ma = -1, w_ca = -1, w_mb = -1;
    int rise_ma = 0, gap_ab = -1, hi_cnt = 0, rise_cb = 0;
    bit p_ma = 1'b0, p_mb = 1'b0, p_cb = 1'b0;

    always @(negedge clk) begin
        if (started && !done) begin
            n_chk++;
            if (main_a !== exp_m[0] || clamp_a !== exp_c[0] || main_b !== exp_m[1] || clamp_b !== exp_c[1]) begin
                n_fail++;
                $display("FAIL %s cyc %0d: act ma=%b ca=%b mb=%b cb=%b exp ma=%b ca=%b mb=%b cb=%b",
                         scen, cyc, main_a, clamp_a, main_b, clamp_b, exp_m[0], exp_c[0], exp_m[1], exp_c[1]);
            end
        end
        if (main_a) run_ma++; else if (run_ma > 0) begin w_ma = run_ma; run_ma = 0; end
        if (clamp_a) run_ca++; else if (run_ca > 0) begin w_ca = run_ca; run_ca = 0; end
        if (main_b) run_mb++; else if (run_mb > 0) begin w_mb = run_mb; run_mb = 0; end
        if (main_a && !p_ma) rise_ma = cyc;
        if (main_b && !p_mb) gap_ab = cyc - rise_ma;
        if (clamp_b && !p_cb) rise_cb++;
        if (main_a || clamp_a || main_b || clamp_b) hi_cnt++;
        p_ma = main_a; p_mb = main_b; p_cb = clamp_b;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input int period);
        @(negedge clk);
        enable = 1'b0; tick_en = 1'b0;
        wait_cyc(3);
        tper = period;
        enable = 1'b1; tick_en = 1'b1;
    endtask

    initial begin
        int lcg;
        // R1: reset and disabled state
        wait_cyc(5);
        check(!(main_a || clamp_a || main_b || clamp_b), "R1 reset outputs", hi_cnt, 0);
        rst = 1'b0;
        tick_en = 1'b1;
        duty_a = 8'd8; duty_b = 8'd12; ovl = 6'd3;
        hi_cnt = 0;
        wait_cyc(60);
        check(hi_cnt == 0, "R1 disabled outputs stay low", hi_cnt, 0);

        // R3/R4/R2: normal interleaved operation
        scen = "R3";
        restart(20);
        wait_cyc(200);
        check(w_ma == 8, "R3 main_a on-time", w_ma, 8);
        check(w_mb == 12, "R4 main_b own on-time", w_mb, 12);
        check(w_ca == 14, "R5 clamp_a window 2v+d", w_ca, 14);
        check(gap_ab == 20, "R2 main_b rises one period after main_a", gap_ab, 20);

        // R5: zero overlap
        scen = "R5";
        ovl = 6'd0;
        wait_cyc(120);
        check(w_ca == w_ma && w_ma == 8, "R5 zero overlap clamp equals main", w_ca, w_ma);

        // R6: on-time limit
        scen = "R6";
        ovl = 6'd3; duty_a = 8'd60;
        wait_cyc(160);
        check(w_ma == 34, "R6 limited on-time", w_ma, 34);
        ovl = 6'd25;
        wait_cyc(60);
        hi_cnt = 0;
        wait_cyc(100);
        check(hi_cnt == 0, "R6 overlap beyond period empties cycle", hi_cnt, 0);

        // R7: runt suppression and boundary
        scen = "R7";
        ovl = 6'd2; duty_a = 8'd1; duty_b = 8'd0;
        wait_cyc(60);
        hi_cnt = 0;
        wait_cyc(100);
        check(hi_cnt == 0, "R7 short on-time suppressed", hi_cnt, 0);
        duty_a = 8'd2;
        wait_cyc(100);
        check(w_ma == 2, "R7 minimum on-time kept", w_ma, 2);

        // R8: mid-cycle changes
        scen = "R8";
        ovl = 6'd3; duty_b = 8'd10; lcg = 7;
        for (int k = 0; k < 45; k++) begin
            lcg = (lcg * 37 + 11) % 251;
            duty_a = 8'(lcg % 30);
            wait_cyc(7);
        end
        check(w_mb == 10, "R8 phase B unaffected by phase A changes", w_mb, 10);

        // R9: first cycle after release is empty
        scen = "R9";
        duty_a = 8'd6; duty_b = 8'd6;
        @(negedge clk);
        enable = 1'b0; tick_en = 1'b0;
        wait_cyc(4);
        tper = 16;
        rise_cb = 0;
        enable = 1'b1; tick_en = 1'b1;
        hi_cnt = 0;
        wait_cyc(16);
        check(hi_cnt == 0, "R9 first phase A cycle empty", hi_cnt, 0);
        wait_cyc(40);
        check(rise_cb > 0, "R2 phase B starts on second tick", rise_cb, 1);

        // R10: fault latching
        scen = "R10";
        fault = 1'b1;
        wait_cyc(3);
        fault = 1'b0;
        wait_cyc(1);
        hi_cnt = 0;
        wait_cyc(100);
        check(hi_cnt == 0, "R10 outputs held off after fault clears", hi_cnt, 0);
        enable = 1'b0;
        wait_cyc(3);
        enable = 1'b1;
        hi_cnt = 0;
        wait_cyc(100);
        check(hi_cnt > 0, "R10 restart after enable toggle", hi_cnt, 1);

        scen = "R1";
        enable = 1'b0;
        wait_cyc(2);
        check(!(main_a || clamp_a || main_b || clamp_b), "R1 enable low clears outputs", hi_cnt, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: act %0d cycles exp completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule